// File: doc/BRIEF.md
# Cartridge Register Ownership Arbiter

Two host processors share one cartridge controller. This block sits between their register buses and that controller. It decides which processor may change the controller's serial-port control register, issue ROM-control words and drain the data port. Ownership is set by one bit of a per-processor external-memory control register. Each processor has its own copy of that register, and the copies take writes through asymmetric masks.

Each host presents a simple register bus. The bus carries a byte address, 32-bit write data, four byte enables, and read and write strobes. Write data sits on the byte lanes given by the enables. A read returns one cycle later with a valid flag. The command buffer and the two pairs of seed registers are held here and driven out to the controller. Only one access is served per cycle. The first processor wins a clash, and the second processor is held off for that cycle.

Top module: `cart_owner_arbiter`

## Requirements
- R1: During and after a synchronous reset, both control copies, the serial-port control register, the command buffer, all seeds and every strobe and response output are zero, so `owner` is 0 (first processor).
- R2: `owner` equals bit 11 of the first processor's control copy. Value 0 means the first processor (port p0) owns the cartridge registers, and 1 means the second (p1).
- R3: A p0 write to offset 0x1C merges the enabled lanes 0..1 into p0's copy. It also copies bits 15:7 of the new value into p1's copy and leaves bits 6:0 of p1's copy unchanged.
- R4: A p1 write to offset 0x1C changes only bits 6:0 of p1's copy (from lane 0), and bits 15:7 keep their value. A read of 0x1C returns the reader's own copy in bits 15:0.
- R5: A write to the 16-bit serial-port control register at 0x00 (lanes 0..1, byte or wider) changes only the enabled bytes, and only when it comes from the owner. Otherwise it is dropped.
- R6: A write to 0x04 with all four enables from the owner pulses `rom_wr` for one cycle in the next cycle, with `rom_wdata` holding the word. Any other write to 0x04 produces no pulse.
- R7: A read of 0x20 by the owner raises `data_pop` in the same cycle and returns `data_word`. A read by the non-owner returns zero and leaves `data_pop` low.
- R8: Reads of 0x00 (serial-port control in bits 15:0) and 0x04 (`rom_ctl` input) are served to either processor regardless of ownership.
- R9: Seed words at 0x10 (seed A) and 0x14 (seed B) merge enabled bytes into the writer's own slot. At 0x18, lane 0 sets the writer's 7-bit seed A upper part from bits 6:0, and lane 2 sets seed B's from bits 22:16. Outputs pack the p0 slot in the low half and the p1 slot in the high half.
- R10: Writes to 0x08 (command bytes 0..3) and 0x0C (bytes 4..7) store enabled lanes from either processor, whatever the ownership. Byte n sits at `cmd_bytes[8n+7:8n]`.
- R11: When both processors access in the same cycle, p0 is served and `p1_wait` is high. A p1 access alone is served, with `p1_wait` low.
- R12: A served read asserts the reader's `rvalid` in the following cycle with the data. Every other cycle, `rvalid` is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_addr | input | 6 | First processor byte address (word aligned) |
| p0_wdata | input | 32 | First processor write data |
| p0_be | input | 4 | First processor byte enables |
| p0_rd | input | 1 | First processor read strobe |
| p0_wr | input | 1 | First processor write strobe |
| p0_rdata | output | 32 | First processor read data |
| p0_rvalid | output | 1 | First processor read data valid |
| p1_addr | input | 6 | Second processor byte address |
| p1_wdata | input | 32 | Second processor write data |
| p1_be | input | 4 | Second processor byte enables |
| p1_rd | input | 1 | Second processor read strobe |
| p1_wr | input | 1 | Second processor write strobe |
| p1_rdata | output | 32 | Second processor read data |
| p1_rvalid | output | 1 | Second processor read data valid |
| p1_wait | output | 1 | Second processor access not served this cycle |
| rom_ctl | input | 32 | Current ROM-control value from the controller |
| data_word | input | 32 | Data-port word offered by the controller |
| data_pop | output | 1 | Data-port word consumed this cycle |
| rom_wr | output | 1 | ROM-control write pulse to the controller |
| rom_wdata | output | 32 | ROM-control word forwarded |
| spi_ctl | output | 16 | Serial-port control register |
| cmd_bytes | output | 64 | Command buffer, byte n in bits 8n+7:8n |
| seed_a_lo | output | 64 | Seed A low words, p0 slot low |
| seed_b_lo | output | 64 | Seed B low words, p0 slot low |
| seed_a_hi | output | 14 | Seed A upper parts, p0 slot low |
| seed_b_hi | output | 14 | Seed B upper parts, p0 slot low |
| owner | output | 1 | Current owner, 0 = p0 |

## Verification
Two processors can reach the block in one cycle, and so can an ownership change and a gated access. The bench issues a p0 serial-port write together with a p1 command write, and then a p0 data-port read together with a p1 data-port read. Each time p1 holds its request into the next cycle. The reference model serves p0 first, expects `p1_wait` high for exactly that cycle, and then applies p1's access against the ownership in force at that point. Other runs switch ownership with a p0 control write and then repeat the gated accesses straight away. Those runs show that the very next access is judged by the new owner bit.

// File: rtl/cart_arb_pkg.sv
package cart_arb_pkg;
  // Register offsets within the arbiter window (byte addresses).
  localparam int OFS_SPI     = 'h00;
  localparam int OFS_ROM     = 'h04;
  localparam int OFS_CMD     = 'h08;
  localparam int OFS_SEED_A  = 'h10;
  localparam int OFS_SEED_B  = 'h14;
  localparam int OFS_SEED_HI = 'h18;
  localparam int OFS_XMC     = 'h1C;
  localparam int OFS_DATA    = 'h20;

  localparam logic SRC_P0 = 1'b0;
  localparam logic SRC_P1 = 1'b1;
endpackage

// File: rtl/cart_arb_grant.sv
module cart_arb_grant #(
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int BE_W = DW / 8
) (
  input  logic            p0_rd,
  input  logic            p0_wr,
  input  logic [AW-1:0]   p0_addr,
  input  logic [DW-1:0]   p0_wdata,
  input  logic [BE_W-1:0] p0_be,
  input  logic            p1_rd,
  input  logic            p1_wr,
  input  logic [AW-1:0]   p1_addr,
  input  logic [DW-1:0]   p1_wdata,
  input  logic [BE_W-1:0] p1_be,
  output logic            g_valid,
  output logic            g_src,
  output logic            g_rd,
  output logic            g_wr,
  output logic [AW-1:0]   g_addr,
  output logic [DW-1:0]   g_wdata,
  output logic [BE_W-1:0] g_be,
  output logic            p1_wait
);
  import cart_arb_pkg::*;

  logic p0_act, p1_act;

  assign p0_act  = p0_rd | p0_wr;
  assign p1_act  = p1_rd | p1_wr;
  assign g_valid = p0_act | p1_act;
  assign p1_wait = p0_act & p1_act;

  // Fixed priority: the first processor always wins a clash.
  always_comb begin
    if (p0_act) begin
      g_src   = SRC_P0;
      g_rd    = p0_rd;
      g_wr    = p0_wr;
      g_addr  = p0_addr;
      g_wdata = p0_wdata;
      g_be    = p0_be;
    end else begin
      g_src   = SRC_P1;
      g_rd    = p1_rd;
      g_wr    = p1_wr;
      g_addr  = p1_addr;
      g_wdata = p1_wdata;
      g_be    = p1_be;
    end
  end
endmodule

// File: rtl/cart_arb_cmdbuf.sv
module cart_arb_cmdbuf #(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int CMD_N = 8,
  localparam int BE_W = DW / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               g_valid,
  input  logic               g_wr,
  input  logic [AW-1:0]      g_addr,
  input  logic [DW-1:0]      g_wdata,
  input  logic [BE_W-1:0]    g_be,
  output logic [CMD_N*8-1:0] cmd_bytes
);
  import cart_arb_pkg::*;

  // Ungated: either processor may fill the shared command buffer.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_bytes <= '0;
    end else if (g_valid && g_wr) begin
      for (int i = 0; i < CMD_N; i++) begin
        if (g_addr == AW'(OFS_CMD + (i / BE_W) * BE_W) && g_be[i % BE_W])
          cmd_bytes[i*8 +: 8] <= g_wdata[(i % BE_W)*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/cart_arb_regs.sv
module cart_arb_regs #(
  parameter int AW        = 6,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int OWN_BIT   = 11,
  parameter int SPLIT     = 7,
  parameter int SEED_HI_W = 7,
  parameter int HI_B_LANE = 2,
  localparam int BE_W = DW / 8,
  localparam int CB   = CW / 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   g_valid,
  input  logic                   g_src,
  input  logic                   g_wr,
  input  logic [AW-1:0]          g_addr,
  input  logic [DW-1:0]          g_wdata,
  input  logic [BE_W-1:0]        g_be,
  output logic                   owner,
  output logic                   from_owner,
  output logic [CW-1:0]          xmc0,
  output logic [CW-1:0]          xmc1,
  output logic [CW-1:0]          spi_ctl,
  output logic                   rom_wr,
  output logic [DW-1:0]          rom_wdata,
  output logic [2*DW-1:0]        seed_a_lo,
  output logic [2*DW-1:0]        seed_b_lo,
  output logic [2*SEED_HI_W-1:0] seed_a_hi,
  output logic [2*SEED_HI_W-1:0] seed_b_hi
);
  import cart_arb_pkg::*;

  logic [CW-1:0]        ctl_merged, spi_merged;
  logic [DW-1:0]        sa_lo [2];
  logic [DW-1:0]        sb_lo [2];
  logic [SEED_HI_W-1:0] sa_hi [2];
  logic [SEED_HI_W-1:0] sb_hi [2];
  logic wr_xmc, wr_spi, wr_rom, wr_sa, wr_sb, wr_hi;

  assign owner      = xmc0[OWN_BIT];
  assign from_owner = (g_src == SRC_P1) ? owner : ~owner;

  assign wr_xmc = g_valid && g_wr && g_addr == AW'(OFS_XMC);
  assign wr_spi = g_valid && g_wr && g_addr == AW'(OFS_SPI);
  assign wr_rom = g_valid && g_wr && g_addr == AW'(OFS_ROM);
  assign wr_sa  = g_valid && g_wr && g_addr == AW'(OFS_SEED_A);
  assign wr_sb  = g_valid && g_wr && g_addr == AW'(OFS_SEED_B);
  assign wr_hi  = g_valid && g_wr && g_addr == AW'(OFS_SEED_HI);

  // Byte-lane merge of the writer's own control copy and of the serial-port register.
  always_comb begin
    ctl_merged = (g_src == SRC_P1) ? xmc1 : xmc0;
    spi_merged = spi_ctl;
    for (int b = 0; b < CB; b++) begin
      if (g_be[b]) begin
        ctl_merged[b*8 +: 8] = g_wdata[b*8 +: 8];
        spi_merged[b*8 +: 8] = g_wdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xmc0      <= '0;
      xmc1      <= '0;
      spi_ctl   <= '0;
      rom_wr    <= 1'b0;
      rom_wdata <= '0;
      for (int s = 0; s < 2; s++) begin
        sa_lo[s] <= '0;
        sb_lo[s] <= '0;
        sa_hi[s] <= '0;
        sb_hi[s] <= '0;
      end
    end else begin
      rom_wr <= 1'b0;
      if (wr_xmc) begin
        if (g_src == SRC_P0) begin
          xmc0 <= ctl_merged;
          xmc1 <= {ctl_merged[CW-1:SPLIT], xmc1[SPLIT-1:0]};
        end else begin
          xmc1 <= {xmc1[CW-1:SPLIT], ctl_merged[SPLIT-1:0]};
        end
      end
      if (wr_spi && from_owner)
        spi_ctl <= spi_merged;
      if (wr_rom && from_owner && (&g_be)) begin
        rom_wr    <= 1'b1;
        rom_wdata <= g_wdata;
      end
      for (int b = 0; b < BE_W; b++) begin
        if (wr_sa && g_be[b]) sa_lo[g_src][b*8 +: 8] <= g_wdata[b*8 +: 8];
        if (wr_sb && g_be[b]) sb_lo[g_src][b*8 +: 8] <= g_wdata[b*8 +: 8];
      end
      if (wr_hi && g_be[0])
        sa_hi[g_src] <= g_wdata[SEED_HI_W-1:0];
      if (wr_hi && g_be[HI_B_LANE])
        sb_hi[g_src] <= g_wdata[HI_B_LANE*8 +: SEED_HI_W];
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      seed_a_lo[s*DW +: DW]               = sa_lo[s];
      seed_b_lo[s*DW +: DW]               = sb_lo[s];
      seed_a_hi[s*SEED_HI_W +: SEED_HI_W] = sa_hi[s];
      seed_b_hi[s*SEED_HI_W +: SEED_HI_W] = sb_hi[s];
    end
  end
endmodule

// File: rtl/cart_owner_arbiter.sv
module cart_owner_arbiter #(
  parameter int AW        = 6,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int OWN_BIT   = 11,
  parameter int SPLIT     = 7,
  parameter int SEED_HI_W = 7,
  parameter int HI_B_LANE = 2,
  parameter int CMD_N     = 8,
  localparam int BE_W = DW / 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          p0_addr,
  input  logic [DW-1:0]          p0_wdata,
  input  logic [BE_W-1:0]        p0_be,
  input  logic                   p0_rd,
  input  logic                   p0_wr,
  output logic [DW-1:0]          p0_rdata,
  output logic                   p0_rvalid,
  input  logic [AW-1:0]          p1_addr,
  input  logic [DW-1:0]          p1_wdata,
  input  logic [BE_W-1:0]        p1_be,
  input  logic                   p1_rd,
  input  logic                   p1_wr,
  output logic [DW-1:0]          p1_rdata,
  output logic                   p1_rvalid,
  output logic                   p1_wait,
  input  logic [DW-1:0]          rom_ctl,
  input  logic [DW-1:0]          data_word,
  output logic                   data_pop,
  output logic                   rom_wr,
  output logic [DW-1:0]          rom_wdata,
  output logic [CW-1:0]          spi_ctl,
  output logic [CMD_N*8-1:0]     cmd_bytes,
  output logic [2*DW-1:0]        seed_a_lo,
  output logic [2*DW-1:0]        seed_b_lo,
  output logic [2*SEED_HI_W-1:0] seed_a_hi,
  output logic [2*SEED_HI_W-1:0] seed_b_hi,
  output logic                   owner
);
  import cart_arb_pkg::*;

  logic            g_valid, g_src, g_rd, g_wr, from_owner;
  logic [AW-1:0]   g_addr;
  logic [DW-1:0]   g_wdata, rd_val;
  logic [BE_W-1:0] g_be;
  logic [CW-1:0]   xmc0, xmc1;
  logic [1:0]      rvalid_q;
  logic [DW-1:0]   rdata_q [2];

  cart_arb_grant #(.AW(AW), .DW(DW)) u_grant (
    .p0_rd(p0_rd), .p0_wr(p0_wr), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_be(p0_be),
    .p1_rd(p1_rd), .p1_wr(p1_wr), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_be(p1_be),
    .g_valid(g_valid), .g_src(g_src), .g_rd(g_rd), .g_wr(g_wr),
    .g_addr(g_addr), .g_wdata(g_wdata), .g_be(g_be), .p1_wait(p1_wait)
  );

  cart_arb_regs #(
    .AW(AW), .DW(DW), .CW(CW), .OWN_BIT(OWN_BIT), .SPLIT(SPLIT),
    .SEED_HI_W(SEED_HI_W), .HI_B_LANE(HI_B_LANE)
  ) u_regs (
    .clk(clk), .rst(rst), .g_valid(g_valid), .g_src(g_src), .g_wr(g_wr),
    .g_addr(g_addr), .g_wdata(g_wdata), .g_be(g_be),
    .owner(owner), .from_owner(from_owner), .xmc0(xmc0), .xmc1(xmc1),
    .spi_ctl(spi_ctl), .rom_wr(rom_wr), .rom_wdata(rom_wdata),
    .seed_a_lo(seed_a_lo), .seed_b_lo(seed_b_lo),
    .seed_a_hi(seed_a_hi), .seed_b_hi(seed_b_hi)
  );

  cart_arb_cmdbuf #(.AW(AW), .DW(DW), .CMD_N(CMD_N)) u_cmd (
    .clk(clk), .rst(rst), .g_valid(g_valid), .g_wr(g_wr),
    .g_addr(g_addr), .g_wdata(g_wdata), .g_be(g_be), .cmd_bytes(cmd_bytes)
  );

  // Data port is consumed only by the owner's read.
  assign data_pop = g_valid && g_rd && (g_addr == AW'(OFS_DATA)) && from_owner;

  always_comb begin
    case (g_addr)
      AW'(OFS_SPI):  rd_val = DW'(spi_ctl);
      AW'(OFS_ROM):  rd_val = rom_ctl;
      AW'(OFS_XMC):  rd_val = DW'((g_src == SRC_P1) ? xmc1 : xmc0);
      AW'(OFS_DATA): rd_val = from_owner ? data_word : '0;
      default:       rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= '0;
      for (int s = 0; s < 2; s++) rdata_q[s] <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        rvalid_q[s] <= g_valid && g_rd && (g_src == 1'(s));
        rdata_q[s]  <= (g_valid && g_rd && (g_src == 1'(s))) ? rd_val : '0;
      end
    end
  end

  assign p0_rvalid = rvalid_q[0];
  assign p1_rvalid = rvalid_q[1];
  assign p0_rdata  = rdata_q[0];
  assign p1_rdata  = rdata_q[1];
endmodule

// File: rtl/cart_arb_checker.sv
module cart_arb_checker #(
  parameter int AW    = 6,
  parameter int CW    = 16,
  parameter int SPLIT = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          p0_rd,
  input logic          p0_wr,
  input logic [AW-1:0] p0_addr,
  input logic          p1_rd,
  input logic          p1_wr,
  input logic [AW-1:0] p1_addr,
  input logic          p1_wait,
  input logic          p0_rvalid,
  input logic          p1_rvalid,
  input logic          data_pop,
  input logic          rom_wr,
  input logic          owner,
  input logic [CW-1:0] x1
);
  import cart_arb_pkg::*;

  logic rst_q;
  logic p0_act, p1_act;
  assign p0_act = p0_rd | p0_wr;
  assign p1_act = p1_rd | p1_wr;

  // R1: the cycle after a reset edge shows the cleared state.
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q)
      a_r1_reset_clear: assert (owner == 1'b0 && !rom_wr && !p0_rvalid && !p1_rvalid);
  end

  a_r11_clash_waits: assert property (@(posedge clk) disable iff (rst)
    (p0_act && p1_act) |-> p1_wait);

  a_r11_alone_no_wait: assert property (@(posedge clk) disable iff (rst)
    !p0_act |-> !p1_wait);

  a_r12_p0_rvalid: assert property (@(posedge clk) disable iff (rst)
    p0_rd |=> p0_rvalid);

  a_r12_p1_rvalid: assert property (@(posedge clk) disable iff (rst)
    (p1_rd && !p0_act) |=> p1_rvalid);

  a_r7_pop_by_owner: assert property (@(posedge clk) disable iff (rst)
    data_pop |-> ((p0_act && !owner) || (!p0_act && p1_act && owner)));

  a_r6_rom_by_owner: assert property (@(posedge clk) disable iff (rst)
    rom_wr |-> (($past(p0_wr) && $past(p0_addr) == AW'(OFS_ROM) && !$past(owner)) ||
                (!$past(p0_act) && $past(p1_wr) && $past(p1_addr) == AW'(OFS_ROM) && $past(owner))));

  a_r4_p1_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (!p0_act && p1_wr && p1_addr == AW'(OFS_XMC)) |=> x1[CW-1:SPLIT] == $past(x1[CW-1:SPLIT]));

  a_r3_p1_lower_kept: assert property (@(posedge clk) disable iff (rst)
    (p0_wr && p0_addr == AW'(OFS_XMC)) |=> x1[SPLIT-1:0] == $past(x1[SPLIT-1:0]));
endmodule

bind cart_owner_arbiter cart_arb_checker #(.AW(AW), .CW(CW), .SPLIT(SPLIT)) u_chk (
  .clk(clk), .rst(rst),
  .p0_rd(p0_rd), .p0_wr(p0_wr), .p0_addr(p0_addr),
  .p1_rd(p1_rd), .p1_wr(p1_wr), .p1_addr(p1_addr),
  .p1_wait(p1_wait), .p0_rvalid(p0_rvalid), .p1_rvalid(p1_rvalid),
  .data_pop(data_pop), .rom_wr(rom_wr), .owner(owner), .x1(xmc1)
);

// File: tb/cart_owner_arbiter_test.sv
module cart_owner_arbiter_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic [5:0]  p0_addr, p1_addr;
  logic [31:0] p0_wdata, p1_wdata, p0_rdata, p1_rdata;
  logic [3:0]  p0_be, p1_be;
  logic        p0_rd, p0_wr, p1_rd, p1_wr, p0_rvalid, p1_rvalid, p1_wait;
  logic [31:0] rom_ctl, data_word, rom_wdata;
  logic        data_pop, rom_wr, owner;
  logic [15:0] spi_ctl;
  logic [63:0] cmd_bytes, seed_a_lo, seed_b_lo;
  logic [13:0] seed_a_hi, seed_b_hi;

  cart_owner_arbiter uut (
    .clk(clk), .rst(rst),
    .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_be(p0_be), .p0_rd(p0_rd), .p0_wr(p0_wr),
    .p0_rdata(p0_rdata), .p0_rvalid(p0_rvalid),
    .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_be(p1_be), .p1_rd(p1_rd), .p1_wr(p1_wr),
    .p1_rdata(p1_rdata), .p1_rvalid(p1_rvalid), .p1_wait(p1_wait),
    .rom_ctl(rom_ctl), .data_word(data_word), .data_pop(data_pop),
    .rom_wr(rom_wr), .rom_wdata(rom_wdata), .spi_ctl(spi_ctl), .cmd_bytes(cmd_bytes),
    .seed_a_lo(seed_a_lo), .seed_b_lo(seed_b_lo), .seed_a_hi(seed_a_hi), .seed_b_hi(seed_b_hi),
    .owner(owner)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference model state
  logic [15:0] m_x0, m_x1, m_spi;
  logic [7:0]  m_cmd [8];
  logic [31:0] m_sa [2], m_sb [2];
  logic [6:0]  m_sah [2], m_sbh [2];
  logic        m_romwr;
  logic [31:0] m_romdata;
  logic        m_rvalid [2];
  logic [31:0] m_rdata [2];

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_x0 = 0; m_x1 = 0; m_spi = 0; m_romwr = 0; m_romdata = 0;
    for (int i = 0; i < 8; i++) m_cmd[i] = 0;
    for (int s = 0; s < 2; s++) begin
      m_sa[s] = 0; m_sb[s] = 0; m_sah[s] = 0; m_sbh[s] = 0;
      m_rvalid[s] = 0; m_rdata[s] = 0;
    end
  endtask

  function automatic logic [31:0] lane_mask(logic [3:0] be);
    logic [31:0] m = 0;
    for (int l = 0; l < 4; l++) if (be[l]) m[l*8 +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic check_regs();
    logic [63:0] cmd_exp;
    for (int i = 0; i < 8; i++) cmd_exp[i*8 +: 8] = m_cmd[i];
    chk("R2 owner", 64'(owner), 64'(m_x0[11]));
    chk("R5 spi_ctl", 64'(spi_ctl), 64'(m_spi));
    chk("R6 rom_wr", 64'(rom_wr), 64'(m_romwr));
    chk("R6 rom_wdata", 64'(rom_wdata), 64'(m_romdata));
    chk("R10 cmd_bytes", cmd_bytes, cmd_exp);
    chk("R9 seed_a_lo", seed_a_lo, {m_sa[1], m_sa[0]});
    chk("R9 seed_b_lo", seed_b_lo, {m_sb[1], m_sb[0]});
    chk("R9 seed_a_hi", 64'(seed_a_hi), 64'({m_sah[1], m_sah[0]}));
    chk("R9 seed_b_hi", 64'(seed_b_hi), 64'({m_sbh[1], m_sbh[0]}));
    chk("R12 p0_rvalid", 64'(p0_rvalid), 64'(m_rvalid[0]));
    chk("R12 p1_rvalid", 64'(p1_rvalid), 64'(m_rvalid[1]));
    chk("R12 p0_rdata", 64'(p0_rdata), 64'(m_rdata[0]));
    chk("R12 p1_rdata", 64'(p1_rdata), 64'(m_rdata[1]));
  endtask

  // One clock: check combinational outputs, let the edge happen, advance the model,
  // then compare registered outputs at the falling edge.
  task automatic tick();
    logic a0, a1, valid, src, rd, wr, owned;
    logic [5:0]  addr;
    logic [31:0] wd, rv, mk;
    logic [3:0]  be;
    logic [15:0] n;
    #2;
    a0 = p0_rd | p0_wr;
    a1 = p1_rd | p1_wr;
    valid = a0 | a1;
    src = !a0;
    addr = a0 ? p0_addr : p1_addr;
    wd   = a0 ? p0_wdata : p1_wdata;
    be   = a0 ? p0_be : p1_be;
    rd   = a0 ? p0_rd : p1_rd;
    wr   = a0 ? p0_wr : p1_wr;
    owned = src ? m_x0[11] : !m_x0[11];
    chk("R11 p1_wait", 64'(p1_wait), 64'(a0 && a1));
    chk("R7 data_pop", 64'(data_pop), 64'(valid && rd && addr == 6'h20 && owned));
    case (addr)
      6'h00: rv = {16'h0, m_spi};
      6'h04: rv = rom_ctl;
      6'h1C: rv = {16'h0, src ? m_x1 : m_x0};
      6'h20: rv = owned ? data_word : 32'h0;
      default: rv = 0;
    endcase
    @(posedge clk);
    #1;
    m_romwr = 0;
    for (int s = 0; s < 2; s++) begin
      m_rvalid[s] = valid && rd && (src == 1'(s));
      m_rdata[s]  = m_rvalid[s] ? rv : 32'h0;
    end
    if (valid && wr) begin
      mk = lane_mask(be);
      case (addr)
        6'h00: if (owned) m_spi = (m_spi & ~mk[15:0]) | (wd[15:0] & mk[15:0]);
        6'h04: if (owned && be == 4'hF) begin m_romwr = 1; m_romdata = wd; end
        6'h08, 6'h0C: for (int l = 0; l < 4; l++)
                        if (be[l]) m_cmd[(addr == 6'h0C ? 4 : 0) + l] = wd[l*8 +: 8];
        6'h10: m_sa[src] = (m_sa[src] & ~mk) | (wd & mk);
        6'h14: m_sb[src] = (m_sb[src] & ~mk) | (wd & mk);
        6'h18: begin
          if (be[0]) m_sah[src] = wd[6:0];
          if (be[2]) m_sbh[src] = wd[22:16];
        end
        6'h1C: begin
          if (!src) begin
            n = (m_x0 & ~mk[15:0]) | (wd[15:0] & mk[15:0]);
            m_x0 = n;
            m_x1 = (n & 16'hFF80) | (m_x1 & 16'h007F);
          end else begin
            n = (m_x1 & ~mk[15:0]) | (wd[15:0] & mk[15:0]);
            m_x1 = (m_x1 & 16'hFF80) | (n & 16'h007F);
          end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    check_regs();
  endtask

  task automatic set0(logic w, logic [5:0] a, logic [31:0] d, logic [3:0] be);
    p0_addr = a; p0_wdata = d; p0_be = be; p0_wr = w; p0_rd = !w;
  endtask
  task automatic set1(logic w, logic [5:0] a, logic [31:0] d, logic [3:0] be);
    p1_addr = a; p1_wdata = d; p1_be = be; p1_wr = w; p1_rd = !w;
  endtask
  task automatic clr0(); p0_rd = 0; p0_wr = 0; endtask
  task automatic clr1(); p1_rd = 0; p1_wr = 0; endtask

  task automatic w0(logic [5:0] a, logic [31:0] d, logic [3:0] be); set0(1, a, d, be); tick(); clr0(); endtask
  task automatic w1(logic [5:0] a, logic [31:0] d, logic [3:0] be); set1(1, a, d, be); tick(); clr1(); endtask
  task automatic r0(logic [5:0] a); set0(0, a, 0, 4'hF); tick(); clr0(); endtask
  task automatic r1(logic [5:0] a); set1(0, a, 0, 4'hF); tick(); clr1(); endtask

  always @(posedge clk) data_word <= data_word + 32'h11;

  initial begin
    #(20 * 4000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R12: actual no end expected end of run");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1; rom_ctl = 32'hA5A5_0F0F; data_word = 32'hD000_0000;
    p0_addr = 0; p0_wdata = 0; p0_be = 0; p0_rd = 0; p0_wr = 0;
    p1_addr = 0; p1_wdata = 0; p1_be = 0; p1_rd = 0; p1_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    // R1: reset state
    chk("R1 p1_wait", 64'(p1_wait), 64'h0);
    chk("R1 data_pop", 64'(data_pop), 64'h0);
    check_regs();

    r0(6'h1C);                         // R4 read own copy after reset
    w0(6'h00, 32'h0000_1234, 4'h3);    // R5 owner p0 writes
    w1(6'h00, 32'h0000_FFFF, 4'h3);    // R5 non-owner dropped
    w0(6'h00, 32'h0000_AB00, 4'h2);    // R5 upper byte only
    w0(6'h04, 32'h8000_1111, 4'hF);    // R6 forwarded
    w1(6'h04, 32'h8000_2222, 4'hF);    // R6 non-owner dropped
    w0(6'h04, 32'h8000_3333, 4'h3);    // R6 partial write not forwarded
    r1(6'h00);                         // R8 ungated
    r1(6'h04);                         // R8 ungated
    r0(6'h20);                         // R7 owner pop
    r1(6'h20);                         // R7 non-owner zero
    w0(6'h1C, 32'h0000_FFFF, 4'h3);    // R3 and R2: ownership to p1
    r1(6'h1C);                         // R4 p1 copy
    w1(6'h1C, 32'h0000_0055, 4'h3);    // R4 low bits only
    w1(6'h1C, 32'h0000_0000, 4'h3);    // R4
    w1(6'h00, 32'h0000_5A5A, 4'h3);    // R5 new owner p1
    w0(6'h00, 32'h0000_0000, 4'h3);    // R5 p0 now dropped
    r1(6'h20);                         // R7 p1 owns data port
    r0(6'h20);                         // R7 p0 sees zero
    w1(6'h04, 32'h0123_4567, 4'hF);    // R6 forwarded from p1
    w0(6'h04, 32'h7654_3210, 4'hF);    // R6 dropped
    r0(6'h00);                         // R8
    w0(6'h1C, 32'h0000_0842, 4'h3);    // R3 still owner p1
    r1(6'h1C);
    w0(6'h1C, 32'h0000_0000, 4'h1);    // R3 lane 0 only, owner stays
    r0(6'h1C);
    w0(6'h1C, 32'h0000_0000, 4'h3);    // R2 back to p0
    w0(6'h08, 32'h4433_2211, 4'hF);    // R10
    w1(6'h0C, 32'h8877_6655, 4'h5);    // R10 non-owner allowed
    w1(6'h08, 32'h0000_EE00, 4'h2);    // R10
    w0(6'h10, 32'hCAFE_F00D, 4'hF);    // R9
    w1(6'h14, 32'hBEEF_1234, 4'hF);    // R9
    w1(6'h10, 32'h0000_00AA, 4'h1);    // R9 own slot
    w0(6'h18, 32'h00FF_00FF, 4'h5);    // R9 mask to 7 bits
    w1(6'h18, 32'h0033_0044, 4'h4);    // R9 lane 2 only
    // R11: clash, p1 holds into next cycle
    set0(1, 6'h00, 32'h0000_0F0F, 4'h3);
    set1(1, 6'h0C, 32'h1122_3344, 4'hF);
    tick(); clr0();
    tick(); clr1();
    set0(0, 6'h20, 0, 4'hF);
    set1(0, 6'h20, 0, 4'hF);
    tick(); clr0();
    tick(); clr1();
    set1(0, 6'h04, 0, 4'hF);           // R11 p1 alone
    tick(); clr1();
    // R11 clash with ownership change, then p1 gated access
    set0(1, 6'h1C, 32'h0000_0800, 4'h3);
    set1(1, 6'h00, 32'h0000_7777, 4'h3);
    tick(); clr0();
    tick(); clr1();
    rom_ctl = 32'h0BAD_CAFE;
    r0(6'h04);                         // R8
    tick(); tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule